// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins two 18-bit tri-state buses, A and B, through two independent one-word paths. The A-to-B path reads bus A and can drive bus B. The B-to-A path reads bus B and can drive bus A. Each path has one storage word that acts in one of three ways:

- as a see-through latch while its pass input is high;
- as a register that loads on a rising edge of its strobe input, when pass is low and the strobe gate is open;
- as a plain hold otherwise.

A separate active-low drive input per path decides whether the path's word is put onto its destination bus or the bus is left floating. The same word and its enable also appear on plain output ports, so a checker can see them without resolving the tri-state bus.

The block runs from one block clock. The per-path strobes are treated as slow control signals sampled by that clock. A strobe edge is a strobe seen low at one block clock edge and high at the next. Each path is a small machine whose mode is worked out every cycle:

- PASS while pass is high.
- CLOCKED for the one cycle in which pass is low, the gate is open and a strobe rise is seen.
- HOLD in every other case.

The transitions are:

- enter PASS when pass rises;
- leave PASS for HOLD when pass falls;
- enter CLOCKED from HOLD on a qualified strobe rise;
- return from CLOCKED to HOLD on the following cycle, unless another qualified rise follows.

Top module: `uxr_transceiver`

## Requirements
- R1: The A-to-B path carries an 18-bit word from `a_bus` to `b_bus`, and the B-to-A path carries one from `b_bus` to `a_bus`. While a path's drive input is low and reset is inactive, its enable output is 1 and its destination bus carries the same value as its data output.
- R2: While a path's pass input is 1, its data output equals its source bus in the same cycle, with no clock edge needed.
- R3: While pass is 1, the storage word is loaded from the source bus at every block clock edge. After pass goes to 0, the data output holds the value sampled at the last block clock edge at which pass was 1.
- R4: With pass at 0 and the gate input at 0, a strobe sampled 0 at one block clock edge and 1 at the next loads the source bus into the storage word at that second edge. The data output shows the new word from that edge on.
- R5: With pass at 0, a strobe that stays 1 or stays 0 leaves the stored word unchanged, whatever the source bus does.
- R6: With pass at 0 and the gate input at 1, a strobe rise leaves the stored word unchanged.
- R7: While a path's drive input is 1, its enable output is 0 and the destination bus is not driven by the block. Its data output still shows the path word.
- R8: The B-to-A path behaves as in R2 to R7, using only its own drive, pass, strobe and gate inputs. A control change on one path never alters the other path's word.
- R9: When both drive inputs are 0 and reset is inactive, `contention` is 1, and otherwise it is 0. A path whose source bus is being driven by the other path ignores that bus: both in pass mode and on a strobe rise, its word stays unchanged.
- R10: While `rst_n` is 0, both storage words are 0 and both enable outputs are 0. The strobe history is reset to 1, so a strobe that is already 1 when reset is released is not counted as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_bus | inout | 18 | Bus A: source of A-to-B, destination of B-to-A |
| b_bus | inout | 18 | Bus B: source of B-to-A, destination of A-to-B |
| ab_drive_n | input | 1 | A-to-B output drive, active low |
| ab_pass | input | 1 | A-to-B see-through select, active high |
| ab_strobe | input | 1 | A-to-B load strobe, rising edge active |
| ab_gate_n | input | 1 | A-to-B strobe gate, active low |
| ba_drive_n | input | 1 | B-to-A output drive, active low |
| ba_pass | input | 1 | B-to-A see-through select, active high |
| ba_strobe | input | 1 | B-to-A load strobe, rising edge active |
| ba_gate_n | input | 1 | B-to-A strobe gate, active low |
| a_out_data | output | 18 | Word of the B-to-A path |
| a_out_en | output | 1 | B-to-A is driving bus A |
| b_out_data | output | 18 | Word of the A-to-B path |
| b_out_en | output | 1 | A-to-B is driving bus B |
| contention | output | 1 | Both paths are driving at once |

## Verification
The bench targets these corner cases:

- A rise with the gate closed. A design that ignored the gate would load a new word.
- A strobe held high, and a strobe that is already high when reset is released. A design that acted on levels, or that started its history at 0, would load spuriously.
- The cycle in which pass falls. A design that latched too late or too early would hold the wrong word.
- Both paths driving at once. A design that let each path sample a bus it is itself driving would circulate values through the two paths and change a word in pass mode.

Each direction is also exercised while the other direction's controls move, to catch a design with crossed control wiring.

// File: rtl/uxr_pkg.sv
`timescale 1ns/1ps
package uxr_pkg;
    typedef enum logic [1:0] {
        XM_HOLD    = 2'd0,
        XM_PASS    = 2'd1,
        XM_CLOCKED = 2'd2
    } xfer_mode_t;

    localparam int unsigned NUM_DIRS = 2;
endpackage

// File: rtl/uxr_edge_sampler.sv
`timescale 1ns/1ps
module uxr_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
        end else begin
            strobe_q <= strobe;
        end
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/uxr_path.sv
`timescale 1ns/1ps
module uxr_path #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         src_busy,
    input  logic         pass,
    input  logic         strobe,
    input  logic         gate_n,
    output logic [W-1:0] dout
);
    import uxr_pkg::*;

    xfer_mode_t   mode_c;
    logic         rise;
    logic [W-1:0] store_q;
    logic [W-1:0] store_d;
    logic [W-1:0] din_eff;

    uxr_edge_sampler u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise)
    );

    // A bus being driven by the other path is not a valid source.
    assign din_eff = src_busy ? store_q : din;

    always_comb begin
        if (pass) begin
            mode_c = XM_PASS;
        end else if (rise && !gate_n) begin
            mode_c = XM_CLOCKED;
        end else begin
            mode_c = XM_HOLD;
        end
    end

    always_comb begin
        unique case (mode_c)
            XM_PASS:    store_d = din_eff;
            XM_CLOCKED: store_d = din_eff;
            XM_HOLD:    store_d = store_q;
            default:    store_d = store_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    always_comb begin
        unique case (mode_c)
            XM_PASS:    dout = din_eff;
            XM_CLOCKED: dout = store_q;
            XM_HOLD:    dout = store_q;
            default:    dout = store_q;
        endcase
    end

    // R2: see-through from the source bus
    p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !src_busy) |-> (dout == din));

    // R3: storage tracks the source while passing
    p_pass_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pass && !src_busy) |=> (store_q == $past(din)));

    // R4: qualified rise loads the source
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && rise && !gate_n && !src_busy) |=> (store_q == $past(din)));

    // R5: no rise, no change
    p_static_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !rise) |=> $stable(store_q));

    // R6: closed gate blocks loading
    p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && gate_n) |=> $stable(store_q));

    // R9: a busy source never alters the word
    p_busy_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        src_busy |=> $stable(store_q));
endmodule

// File: rtl/uxr_transceiver.sv
`timescale 1ns/1ps
module uxr_transceiver #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    inout  wire [WIDTH-1:0]  a_bus,
    inout  wire [WIDTH-1:0]  b_bus,
    input  logic             ab_drive_n,
    input  logic             ab_pass,
    input  logic             ab_strobe,
    input  logic             ab_gate_n,
    input  logic             ba_drive_n,
    input  logic             ba_pass,
    input  logic             ba_strobe,
    input  logic             ba_gate_n,
    output logic [WIDTH-1:0] a_out_data,
    output logic             a_out_en,
    output logic [WIDTH-1:0] b_out_data,
    output logic             b_out_en,
    output logic             contention
);
    import uxr_pkg::*;

    // index 0 = A-to-B, index 1 = B-to-A
    logic [NUM_DIRS-1:0][WIDTH-1:0] src_w;
    logic [NUM_DIRS-1:0][WIDTH-1:0] out_w;
    logic [NUM_DIRS-1:0]            drv_n;
    logic [NUM_DIRS-1:0]            pas;
    logic [NUM_DIRS-1:0]            stb;
    logic [NUM_DIRS-1:0]            gte_n;
    logic [NUM_DIRS-1:0]            en;

    assign src_w[0] = a_bus;
    assign src_w[1] = b_bus;
    assign drv_n    = {ba_drive_n, ab_drive_n};
    assign pas      = {ba_pass, ab_pass};
    assign stb      = {ba_strobe, ab_strobe};
    assign gte_n    = {ba_gate_n, ab_gate_n};

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        uxr_path #(.W(WIDTH)) u_path (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (src_w[d]),
            .src_busy (~drv_n[NUM_DIRS-1-d]),
            .pass     (pas[d]),
            .strobe   (stb[d]),
            .gate_n   (gte_n[d]),
            .dout     (out_w[d])
        );
        assign en[d] = rst_n & ~drv_n[d];
    end

    assign b_out_data = out_w[0];
    assign b_out_en   = en[0];
    assign a_out_data = out_w[1];
    assign a_out_en   = en[1];
    assign contention = &en;

    assign b_bus = en[0] ? out_w[0] : {WIDTH{1'bz}};
    assign a_bus = en[1] ? out_w[1] : {WIDTH{1'bz}};

    // R1: a driven bus carries the path word
    p_bus_b_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        b_out_en |-> (b_bus == b_out_data));
    p_bus_a_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        a_out_en |-> (a_bus == a_out_data));

    // R9: words frozen while both paths drive
    p_contend_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (contention && $past(contention)) |-> ($stable(a_out_data) && $stable(b_out_data)));

    // R10: nothing driven in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_float_r10: assert (!a_out_en && !b_out_en && !contention);
        end
    end
endmodule

// File: tb/sim_uxr_transceiver.sv
`timescale 1ns/1ps
module sim_uxr_transceiver;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ab_drive_n = 1'b1, ab_pass = 1'b0, ab_strobe = 1'b0, ab_gate_n = 1'b1;
    logic ba_drive_n = 1'b1, ba_pass = 1'b0, ba_strobe = 1'b0, ba_gate_n = 1'b1;
    logic [W-1:0] tb_a = '0, tb_b = '0;
    wire  [W-1:0] a_bus, b_bus;
    logic [W-1:0] a_out_data, b_out_data;
    logic a_out_en, b_out_en, contention;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit m_abp = 1'b1, m_bap = 1'b1;

    always #10 clk = ~clk;

    // bench drives a bus only when the block does not
    assign a_bus = ba_drive_n ? tb_a : {W{1'bz}};
    assign b_bus = ab_drive_n ? tb_b : {W{1'bz}};

    uxr_transceiver #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a_bus(a_bus), .b_bus(b_bus),
        .ab_drive_n(ab_drive_n), .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_gate_n(ab_gate_n),
        .ba_drive_n(ba_drive_n), .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_gate_n(ba_gate_n),
        .a_out_data(a_out_data), .a_out_en(a_out_en),
        .b_out_data(b_out_data), .b_out_en(b_out_en), .contention(contention)
    );

    task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: compare at negedge, advance the model at posedge
    task automatic cycle(input string tag);
        logic [W-1:0] din_ab, din_ba, exp_b, exp_a;
        bit eb, ea;
        @(negedge clk);
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; m_abp = 1'b1; m_bap = 1'b1;
        end
        din_ab = !ba_drive_n ? m_ab : tb_a;
        din_ba = !ab_drive_n ? m_ba : tb_b;
        exp_b  = ab_pass ? din_ab : m_ab;
        exp_a  = ba_pass ? din_ba : m_ba;
        eb = rst_n && !ab_drive_n;
        ea = rst_n && !ba_drive_n;
        chk(tag, "b_out_data", b_out_data, exp_b);
        chk(tag, "a_out_data", a_out_data, exp_a);
        chk(tag, "b_out_en", {17'd0, b_out_en}, {17'd0, eb});
        chk(tag, "a_out_en", {17'd0, a_out_en}, {17'd0, ea});
        chk(tag, "contention", {17'd0, contention}, {17'd0, ea && eb});
        if (eb) chk(tag, "b_bus", b_bus, exp_b);
        if (ea) chk(tag, "a_bus", a_bus, exp_a);
        @(posedge clk);
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; m_abp = 1'b1; m_bap = 1'b1;
        end else begin
            if (ab_pass || (ab_strobe && !m_abp && !ab_gate_n)) m_ab = din_ab;
            if (ba_pass || (ba_strobe && !m_bap && !ba_gate_n)) m_ba = din_ba;
            m_abp = ab_strobe;
            m_bap = ba_strobe;
        end
        #2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: reset state, strobes high through reset
        ab_strobe = 1'b1; ba_strobe = 1'b1; ab_gate_n = 1'b0; ba_gate_n = 1'b0;
        ab_drive_n = 1'b0; ba_drive_n = 1'b1; tb_a = 18'h2AAAA;
        cycle("R10"); cycle("R10");
        @(negedge clk); rst_n = 1'b1;
        cycle("R10"); cycle("R10");            // high strobe is no rise
        chk("R10", "b word after reset", b_out_data, 18'h0);

        // R1 R2: A-to-B see-through
        ab_pass = 1'b1;
        foreach (tb_a[i]) begin end
        tb_a = 18'h12345; cycle("R2");
        tb_a = 18'h3FFFF; cycle("R1");
        tb_a = 18'h00001; cycle("R2");
        tb_a = 18'h2B3C4; cycle("R2");
        // R3: drop pass, hold last passed word
        ab_pass = 1'b0; tb_a = 18'h11111; cycle("R3");
        tb_a = 18'h22222; cycle("R3");
        chk("R3", "b word held", b_out_data, 18'h2B3C4);

        // R5: strobe held low, then held high
        ab_strobe = 1'b0; cycle("R5"); cycle("R5");
        tb_a = 18'h0F0F0; cycle("R5");
        // R6: rise with gate closed
        ab_gate_n = 1'b1; ab_strobe = 1'b1; cycle("R6"); cycle("R6");
        chk("R6", "b word gated", b_out_data, 18'h2B3C4);
        // R4: qualified rise
        ab_strobe = 1'b0; ab_gate_n = 1'b0; cycle("R4");
        ab_strobe = 1'b1; cycle("R4");
        chk("R4", "b word loaded", b_out_data, 18'h0F0F0);
        tb_a = 18'h33333; cycle("R5"); cycle("R5");   // held high
        chk("R5", "b word static", b_out_data, 18'h0F0F0);
        ab_strobe = 1'b0; tb_a = 18'h05A5A; cycle("R4");
        ab_strobe = 1'b1; cycle("R4");
        ab_strobe = 1'b0; cycle("R4");

        // R7: release bus B
        ab_drive_n = 1'b1; tb_b = 18'h1C0DE; cycle("R7"); cycle("R7");
        chk("R7", "b_out_en", {17'd0, b_out_en}, 18'd0);

        // R8: B-to-A with A-to-B controls toggling
        ba_drive_n = 1'b0; ba_pass = 1'b1; tb_b = 18'h0BEEF; cycle("R8");
        ab_strobe = 1'b1; tb_b = 18'h3C3C3; cycle("R8");
        ba_pass = 1'b0; ab_strobe = 1'b0; tb_b = 18'h00AA0; cycle("R8");
        ba_strobe = 1'b0; ba_gate_n = 1'b1; cycle("R8");
        ba_strobe = 1'b1; cycle("R8");                  // gated rise
        chk("R8", "a word gated", a_out_data, 18'h3C3C3);
        ba_strobe = 1'b0; ba_gate_n = 1'b0; cycle("R8");
        ba_strobe = 1'b1; cycle("R8");
        chk("R8", "a word loaded", a_out_data, 18'h00AA0);
        ba_drive_n = 1'b1; cycle("R8");

        // R9: both paths driving
        ba_drive_n = 1'b0; ab_drive_n = 1'b0; cycle("R9");
        ab_pass = 1'b1; ba_pass = 1'b1; cycle("R9"); cycle("R9");
        ab_pass = 1'b0; ba_pass = 1'b0; ab_strobe = 1'b0; ba_strobe = 1'b0; cycle("R9");
        ab_strobe = 1'b1; ba_strobe = 1'b1; cycle("R9"); cycle("R9");
        chk("R9", "b word frozen", b_out_data, 18'h05A5A);
        chk("R9", "a word frozen", a_out_data, 18'h00AA0);
        ba_drive_n = 1'b1; ab_strobe = 1'b0; ba_strobe = 1'b0; cycle("R9");

        // R10: reset mid-run, strobe held high across release
        ab_strobe = 1'b1; rst_n = 1'b0; cycle("R10");
        rst_n = 1'b1; tb_a = 18'h3ABCD; cycle("R10"); cycle("R10");
        chk("R10", "b word after rerun", b_out_data, 18'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule